// File: doc/BRIEF.md
# Throttled Line-Granular Prefetch Issuer

This block sits next to a cache and takes in already-translated block prefetch commands, each no larger than one page, described by a physical start address and a byte count. It splits every command into a stream of cache-line requests and sends them to the cache request port. The cache line is 128 bytes. Up to four commands can be in progress at once. The block serves them one line at a time in round-robin order, so no single large command holds the port on its own.

The same cache port is shared by three requesters. CPU demand requests have the highest priority. Hardware-prefetcher requests come second. The block's own line prefetches come last.

When the cache refuses any presented request, the block enters a throttled state and stops all block prefetch issue. It leaves that state only after a demand request has again been accepted. A status output shows whether the block is throttled.

Top module: `pfx_line_issuer`

## Requirements
- R1: The first line requested for a command is its start address rounded down to a 128-byte boundary. Each following line of that command is 128 bytes higher. All block requests carry source code 2 on `cache_src`.
- R2: The last line requested for a command is the line that holds the command's final byte (start + size − 1). A command with size 0 is accepted and produces no line request.
- R3: When several commands are pending, one line is issued per command per turn, in ascending slot order with wrap-around. After reset the first turn belongs to slot 0. New commands go to the lowest-numbered free slot.
- R4: A demand request always wins the port and is shown with source code 0. `dmd_ready` equals `cache_ready` whenever a demand is valid.
- R5: A hardware-prefetcher request is shown with source code 1 and wins over any block line. `hwp_ready` is low while a demand is valid.
- R6: At most one request is presented per cycle. `cache_valid` is high exactly when at least one requester is eligible. A line counts as issued only in a cycle where `cache_valid` and `cache_ready` are both high.
- R7: A cycle with `cache_valid` high and `cache_ready` low sets `throttled` in the next cycle. While `throttled` is high, no block line is presented. Hardware-prefetcher and demand requests are still passed through.
- R8: `throttled` goes low in the cycle after a demand handshake, and block issue resumes from the line that was pending.
- R9: There are four command slots. `cmd_ready` is low while all four are busy. A slot becomes free in the cycle after the handshake of its last line.
- R10: After reset `throttled` is low, `cmd_ready` is high and, with no requesters, `cache_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Prefetch command offered |
| cmd_ready | output | 1 | A command slot is free |
| cmd_addr | input | ADDR_W | Physical start address of the command |
| cmd_size | input | SIZE_W | Command length in bytes |
| dmd_valid | input | 1 | CPU demand request offered |
| dmd_ready | output | 1 | Demand request taken by the cache |
| dmd_addr | input | ADDR_W | Demand address |
| hwp_valid | input | 1 | Hardware-prefetcher request offered |
| hwp_ready | output | 1 | Hardware-prefetcher request taken |
| hwp_addr | input | ADDR_W | Hardware-prefetcher address |
| cache_valid | output | 1 | Request presented to the cache |
| cache_ready | input | 1 | Cache accepts the presented request |
| cache_addr | output | ADDR_W | Address of the presented request |
| cache_src | output | 2 | Source of the request: 0 demand, 1 hardware prefetcher, 2 block |
| throttled | output | 1 | Block prefetch issue is suspended |

## Verification
The bench sends commands that start mid-line, end exactly on a line boundary, span a full page, and have zero length. A design that rounded the first or last line wrongly would issue one line too many or one too few. A design that mishandled zero length would request a stray line or hang a slot.

Two overlapping commands must come out strictly interleaved. A design that drained one command first would show the second command's lines late.

The throttle sequence checks three things: a refusal must suspend only block lines, the hardware prefetcher must keep flowing, and issue must resume only after a demand handshake, at the same pending line. Filling all four slots checks that `cmd_ready` falls and then comes back one cycle after the freeing handshake.

// File: rtl/pfx_pkg.sv
// Shared constants for the prefetch line issuer.
// Assumes: source codes are read by the cache side as a 2-bit field.
package pfx_pkg;
    localparam logic [1:0] SRC_DMD = 2'd0;
    localparam logic [1:0] SRC_HWP = 2'd1;
    localparam logic [1:0] SRC_BLK = 2'd2;
endpackage

// File: rtl/pfx_slot.sv
// One command slot: holds the current and final line number of a command
// and steps through them as lines are accepted.
// Assumes: load and adv are never high together (load only targets a free slot).
module pfx_slot #(
    parameter int LW = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [LW-1:0] first_ln,
    input  logic [LW-1:0] last_ln,
    input  logic          adv,
    output logic          busy,
    output logic [LW-1:0] cur_ln
);
    logic [LW-1:0] end_ln;

    // Capture a new command, or advance / retire on an accepted line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cur_ln <= '0;
            end_ln <= '0;
        end else if (load) begin
            busy   <= 1'b1;
            cur_ln <= first_ln;
            end_ln <= last_ln;
        end else if (adv) begin
            if (cur_ln == end_ln) begin
                busy <= 1'b0;
            end else begin
                cur_ln <= cur_ln + 1'b1;
            end
        end
    end

    // R9
    adv_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> busy);

    // R9
    no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);
endmodule

// File: rtl/pfx_rr_pick.sv
// Round-robin picker: chooses the first requesting slot after the one served
// last, and moves its pointer when the chosen slot is served.
// Assumes: adv is only raised while any is high.
module pfx_rr_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          adv,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic [IW-1:0] last_q;

    // Search from the slot after the last served one, wrapping around.
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int off = 1; off <= N; off++) begin
            int c;
            c = (int'(last_q) + off) % N;
            if (!any && req[c]) begin
                any = 1'b1;
                idx = IW'(c);
            end
        end
        grant = any ? (N'(1) << idx) : '0;
    end

    // Remember the slot that was served last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= IW'(N - 1);
        end else if (adv) begin
            last_q <= idx;
        end
    end

    // R3
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~req) == '0));
endmodule

// File: rtl/pfx_port_arb.sv
// Fixed-priority arbiter for the cache port: demand, then hardware
// prefetcher, then block line.
// Assumes: blk_valid is already gated by the throttle state.
module pfx_port_arb
    import pfx_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          dmd_valid,
    input  logic [AW-1:0] dmd_addr,
    input  logic          hwp_valid,
    input  logic [AW-1:0] hwp_addr,
    input  logic          blk_valid,
    input  logic [AW-1:0] blk_addr,
    input  logic          cache_ready,
    output logic          cache_valid,
    output logic [AW-1:0] cache_addr,
    output logic [1:0]    cache_src,
    output logic          dmd_ready,
    output logic          hwp_ready,
    output logic          blk_ready
);
    // Select the highest-priority requester and route the ready back.
    always_comb begin
        cache_valid = dmd_valid | hwp_valid | blk_valid;
        dmd_ready   = cache_ready;
        hwp_ready   = cache_ready & ~dmd_valid;
        blk_ready   = cache_ready & ~dmd_valid & ~hwp_valid;
        if (dmd_valid) begin
            cache_addr = dmd_addr;
            cache_src  = SRC_DMD;
        end else if (hwp_valid) begin
            cache_addr = hwp_addr;
            cache_src  = SRC_HWP;
        end else begin
            cache_addr = blk_addr;
            cache_src  = SRC_BLK;
        end
    end
endmodule

// File: rtl/pfx_line_issuer.sv
// Top of the throttled line-granular prefetch issuer. It holds up to SLOTS
// page-sized commands, issues their lines round-robin at the lowest port
// priority, and suspends block issue after any cache refusal until a demand
// request is accepted again.
// Assumes: start + size does not wrap the address space; size <= one page.
module pfx_line_issuer
    import pfx_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 13,
    parameter int LINE_BYTES = 128,
    parameter int SLOTS      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [SIZE_W-1:0] cmd_size,
    input  logic              dmd_valid,
    output logic              dmd_ready,
    input  logic [ADDR_W-1:0] dmd_addr,
    input  logic              hwp_valid,
    output logic              hwp_ready,
    input  logic [ADDR_W-1:0] hwp_addr,
    output logic              cache_valid,
    input  logic              cache_ready,
    output logic [ADDR_W-1:0] cache_addr,
    output logic [1:0]        cache_src,
    output logic              throttled
);
    localparam int LSH = $clog2(LINE_BYTES);
    localparam int LW  = ADDR_W - LSH;
    localparam int IW  = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [SLOTS-1:0] busy, load, adv, grant;
    logic [LW-1:0]    slot_ln [SLOTS];
    logic [LW-1:0]    first_ln, last_ln;
    logic [ADDR_W-1:0] end_addr, blk_addr;
    logic [IW-1:0]    free_idx, pick_idx;
    logic             pick_any, blk_valid, blk_ready, blk_hs;

    // Line numbers of the first and final byte of the incoming command.
    always_comb begin
        end_addr = cmd_addr + ADDR_W'(cmd_size) - 1'b1;
        first_ln = LW'(cmd_addr >> LSH);
        last_ln  = LW'(end_addr >> LSH);
    end

    // Lowest free slot and load strobes; zero-size commands load nothing.
    always_comb begin
        free_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!busy[i]) free_idx = IW'(i);
        end
        cmd_ready = ~&busy;
        for (int i = 0; i < SLOTS; i++) begin
            load[i] = cmd_valid && cmd_ready && (cmd_size != '0) &&
                      (free_idx == IW'(i));
        end
    end

    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_slot
            pfx_slot #(.LW(LW)) slot_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (load[g]),
                .first_ln (first_ln),
                .last_ln  (last_ln),
                .adv      (adv[g]),
                .busy     (busy[g]),
                .cur_ln   (slot_ln[g])
            );
        end
    endgenerate

    pfx_rr_pick #(.N(SLOTS)) pick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (busy),
        .adv   (blk_hs),
        .grant (grant),
        .idx   (pick_idx),
        .any   (pick_any)
    );

    // Block candidate: the picked slot's line, withheld while throttled.
    always_comb begin
        blk_valid = pick_any && !throttled;
        blk_addr  = {slot_ln[pick_idx], {LSH{1'b0}}};
        blk_hs    = blk_valid && blk_ready;
        adv       = blk_hs ? grant : '0;
    end

    pfx_port_arb #(.AW(ADDR_W)) arb_i (
        .dmd_valid   (dmd_valid),
        .dmd_addr    (dmd_addr),
        .hwp_valid   (hwp_valid),
        .hwp_addr    (hwp_addr),
        .blk_valid   (blk_valid),
        .blk_addr    (blk_addr),
        .cache_ready (cache_ready),
        .cache_valid (cache_valid),
        .cache_addr  (cache_addr),
        .cache_src   (cache_src),
        .dmd_ready   (dmd_ready),
        .hwp_ready   (hwp_ready),
        .blk_ready   (blk_ready)
    );

    // Throttle state: set by a refusal, cleared by an accepted demand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            throttled <= 1'b0;
        end else if (dmd_valid && cache_ready) begin
            throttled <= 1'b0;
        end else if (cache_valid && !cache_ready) begin
            throttled <= 1'b1;
        end
    end

    // R7
    refuse_sets_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_valid && !cache_ready) |=> throttled);

    // R7
    thr_blocks_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        throttled |-> !(cache_valid && cache_src == SRC_BLK));

    // R8
    dmd_clears_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmd_valid && cache_ready) |=> !throttled);

    // R4
    dmd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmd_valid |-> (cache_valid && cache_src == SRC_DMD && cache_addr == dmd_addr));

    // R5
    hwp_over_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hwp_valid && !dmd_valid) |-> (cache_src == SRC_HWP && cache_addr == hwp_addr));

    // R9
    full_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy) |-> !cmd_ready);
endmodule

// File: tb/pfx_line_issuer_tb.sv
module pfx_line_issuer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    localparam logic [31:0] V_ADDR  [NV] = '{32'h1000, 32'h1010, 32'h2000, 32'h207F, 32'h3080, 32'h4000};
    localparam logic [12:0] V_SIZE  [NV] = '{13'd128, 13'd128, 13'd4096, 13'd1, 13'd257, 13'd0};
    localparam logic [31:0] V_FIRST [NV] = '{32'h1000, 32'h1000, 32'h2000, 32'h2000, 32'h3080, 32'h0};
    localparam int          V_CNT   [NV] = '{1, 2, 32, 1, 3, 0};

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid, cmd_ready, dmd_valid, dmd_ready, hwp_valid, hwp_ready;
    logic cache_valid, cache_ready, throttled;
    logic [31:0] cmd_addr, dmd_addr, hwp_addr, cache_addr;
    logic [12:0] cmd_size;
    logic [1:0]  cache_src;
    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pfx_line_issuer dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_size(cmd_size),
        .dmd_valid(dmd_valid), .dmd_ready(dmd_ready), .dmd_addr(dmd_addr),
        .hwp_valid(hwp_valid), .hwp_ready(hwp_ready), .hwp_addr(hwp_addr),
        .cache_valid(cache_valid), .cache_ready(cache_ready), .cache_addr(cache_addr),
        .cache_src(cache_src), .throttled(throttled)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_valid = 0; dmd_valid = 0; hwp_valid = 0; cache_ready = 1;
        cmd_addr = 0; cmd_size = 0; dmd_addr = 0; hwp_addr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Offer one command at a negedge; it is taken at the following posedge.
    task automatic send_cmd(input logic [31:0] a, input logic [12:0] s, input string req);
        cmd_valid = 1; cmd_addr = a; cmd_size = s;
        #1 chk(cmd_ready == 1'b1, req, cmd_ready, 1);
        @(negedge clk);
        cmd_valid = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        // R10 reset state
        #1;
        chk(throttled == 0, "R10 throttled", throttled, 0);
        chk(cmd_ready == 1, "R10 cmd_ready", cmd_ready, 1);
        chk(cache_valid == 0, "R10 cache_valid", cache_valid, 0);
        @(negedge clk);

        // R1 R2 R6: table of single commands, lines counted by handshake
        for (int v = 0; v < NV; v++) begin
            int n;
            logic [31:0] prev;
            n = 0; prev = 0;
            send_cmd(V_ADDR[v], V_SIZE[v], "R2 accept");
            for (int c = 0; c < 40; c++) begin
                #1;
                if (cache_valid && cache_ready) begin
                    chk(cache_src == 2'd2, "R1 src", cache_src, 2);
                    if (n == 0) chk(cache_addr == V_FIRST[v], "R1 first line", cache_addr, V_FIRST[v]);
                    else chk(cache_addr == prev + 32'd128, "R1 next line", cache_addr, prev + 32'd128);
                    prev = cache_addr; n++;
                end
                @(negedge clk);
            end
            chk(n == V_CNT[v], "R2 line count", n, V_CNT[v]);
        end

        // R3 interleave of two commands
        do_reset();
        hwp_valid = 1; hwp_addr = 32'h9000;
        send_cmd(32'h10000, 13'd256, "R3 accept A");
        send_cmd(32'h20000, 13'd384, "R3 accept B");
        hwp_valid = 0;
        begin
            logic [31:0] exp_seq [5] = '{32'h10000, 32'h20000, 32'h10080, 32'h20080, 32'h20100};
            for (int k = 0; k < 5; k++) begin
                #1 chk(cache_valid && cache_addr == exp_seq[k], "R3 rr order", cache_addr, exp_seq[k]);
                @(negedge clk);
            end
            #1 chk(cache_valid == 0, "R6 idle after drain", cache_valid, 0);
        end

        // R4 R5 priorities
        do_reset();
        hwp_valid = 1; hwp_addr = 32'h9000;
        send_cmd(32'h6000, 13'd128, "R4 accept");
        dmd_valid = 1; dmd_addr = 32'hA000;
        #1;
        chk(cache_src == 0 && cache_addr == 32'hA000, "R4 demand wins", cache_addr, 32'hA000);
        chk(dmd_ready == 1 && hwp_ready == 0, "R5 hwp held by demand", {dmd_ready, hwp_ready}, 2'b10);
        @(negedge clk); dmd_valid = 0;
        #1 chk(cache_src == 1 && cache_addr == 32'h9000 && hwp_ready, "R5 hwp over block", cache_addr, 32'h9000);
        @(negedge clk); hwp_valid = 0;
        #1 chk(cache_src == 2 && cache_addr == 32'h6000, "R6 block last", cache_addr, 32'h6000);
        @(negedge clk);

        // R7 R8 throttle
        do_reset();
        hwp_valid = 1; hwp_addr = 32'h9100;
        send_cmd(32'h5000, 13'd512, "R7 accept");
        hwp_valid = 0; cache_ready = 0;
        #1 chk(cache_valid && cache_src == 2 && !throttled, "R7 pre-refusal", throttled, 0);
        @(negedge clk); cache_ready = 1;
        #1 chk(throttled == 1, "R7 throttled set", throttled, 1);
        chk(cache_valid == 0, "R7 block withheld", cache_valid, 0);
        @(negedge clk); hwp_valid = 1;
        #1 chk(cache_src == 1 && hwp_ready == 1, "R7 hwp still served", hwp_ready, 1);
        @(negedge clk); hwp_valid = 0; dmd_valid = 1; dmd_addr = 32'hB000;
        #1 chk(throttled == 1 && cache_src == 0, "R8 held until demand", throttled, 1);
        @(negedge clk); dmd_valid = 0;
        #1 chk(throttled == 0, "R8 throttle cleared", throttled, 0);
        chk(cache_valid && cache_src == 2 && cache_addr == 32'h5000, "R8 resume pending line", cache_addr, 32'h5000);
        @(negedge clk);

        // R9 slot occupancy
        do_reset();
        hwp_valid = 1;
        for (int k = 0; k < 4; k++) send_cmd(32'h7000 + 32'(k) * 32'h1000, 13'd128, "R9 fill");
        #1 chk(cmd_ready == 0, "R9 full", cmd_ready, 0);
        @(negedge clk); hwp_valid = 0;
        #1 chk(cmd_ready == 0 && cache_addr == 32'h7000, "R9 still full", cmd_ready, 0);
        @(negedge clk);
        #1 chk(cmd_ready == 1, "R9 slot freed", cmd_ready, 1);
        @(negedge clk);

        finish_run();
    end
endmodule